// File: doc/BRIEF.md
# Multichannel ADC Serial Output Framer

This block is the digital back end of a four-channel, 12-bit sampling converter. Each channel delivers a parallel word. The block picks up one word per channel at every frame boundary and can recode it between offset binary and two's complement. It can also replace all lanes with a fixed test word. Each word is then serialised on its own lane, least significant bit first. Every lane shares one bit-time enable and one frame strobe.

One clock cycle is one bit time, so a frame lasts twelve cycles. A state machine with three states steps through each frame. `ST_OFF` is the parked state for reset and power-down. `ST_HEAD` covers bit times 0 to 5 and drives the frame strobe high. `ST_TAIL` covers bit times 6 to 11 and drives it low. The transitions are as follows:
- `wake` goes from `ST_OFF` to `ST_HEAD` when power-down is low and loads a word.
- `half` goes from `ST_HEAD` to `ST_TAIL` after bit time 5.
- `wrap` goes from `ST_TAIL` to `ST_HEAD` after bit time 11 and loads the next word.
- `sleep` goes from any state to `ST_OFF` whenever power-down is high.

Top module: `adc_lane_framer`

## Requirements
- R1: While reset is asserted, every lane, the bit enable and the frame strobe are 0.
- R2: A word loaded at a frame boundary leaves its lane least significant bit first: bit 0 in bit time 0 of the frame, through bit 11 in bit time 11.
- R3: The frame strobe is high for bit times 0 to 5 and low for bit times 6 to 11, so it rises together with bit 0 and repeats every 12 bit times.
- R4: The bit enable is high in every cycle that follows a cycle with power-down low, and low while the block is powered down.
- R5: A parallel word is taken only at a frame boundary. A valid word that arrives during a frame does not change the word on the lanes in that frame. The latest valid word is sent in the next frame.
- R6: If no valid word has arrived since the last boundary, the previously held word is sent again.
- R7: With the format select at 1, bit 11 of each word is inverted (0x800 becomes 0x000). With it at 0, the word passes unchanged. The select is sampled at the load.
- R8: With the test enable high at the load, every lane sends 0x0BD (binary 000010111101), least significant bit first, whatever the data and the format select.
- R9: Power-down, sampled at a clock edge, forces all lanes, the frame strobe and the bit enable to 0 from the next cycle and resets the bit count. After release, the first active cycle is bit time 0 of a fresh frame.
- R10: Lane n carries only channel n, where channel n occupies bits 12n+11 down to 12n of the parallel input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_valid | input | 1 | Parallel words on sample_data are valid this cycle |
| sample_data | input | 48 | Four 12-bit words, channel 0 in the low bits |
| fmt_twos | input | 1 | 1 selects inversion of bit 11 (coding swap) |
| test_en | input | 1 | 1 sends the fixed test word on all lanes |
| pwr_dn | input | 1 | Power-down, active high |
| ser_data | output | 4 | Serial data, one bit per lane |
| bit_en | output | 1 | High in every active bit time |
| frame | output | 1 | Frame strobe, high in the first half of each word |

## Verification
The bench takes each frame from the first cycle of the strobe and rebuilds every lane's word from it. This shows up a reversed bit order, a strobe that is one bit off, a crossed lane, or a recoding that touches the wrong bit. A valid pulse in mid-frame tests boundary capture: a design that loads words as they arrive would corrupt the frame in flight. A silent input that follows exposes a design that clears its held word. The test word is sent under both format settings, which catches a design that recodes the pattern. A power-down and release sequence checks that the outputs fall quiet and that the first frame after release starts at bit 0 with the strobe high, not partway through a word.

// File: rtl/afr_pkg.sv
package afr_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_HEAD = 2'd1,
        ST_TAIL = 2'd2
    } seq_state_e;

endpackage

// File: rtl/afr_sequencer.sv
module afr_sequencer
    import afr_pkg::*;
#(
    parameter int WORD_W = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_dn,
    output logic load,
    output logic shift,
    output logic clear,
    output logic bit_en,
    output logic frame
);
    localparam int CW   = $clog2(WORD_W);
    localparam int HALF = WORD_W / 2;
    localparam int LAST = WORD_W - 1;

    seq_state_e     state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic           at_last;

    assign at_last = (cnt_q == CW'(LAST));

    // next-state and count
    always_comb begin
        state_d = state_q;
        cnt_d   = '0;
        if (pwr_dn) begin
            state_d = ST_OFF;                  // sleep
        end else begin
            unique case (state_q)
                ST_OFF:  state_d = ST_HEAD;    // wake
                ST_HEAD: begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == CW'(HALF - 1)) state_d = ST_TAIL;   // half
                end
                ST_TAIL: begin
                    cnt_d = at_last ? '0 : cnt_q + 1'b1;
                    if (at_last) state_d = ST_HEAD;                 // wrap
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        load   = !pwr_dn && ((state_q == ST_OFF) || (state_q == ST_TAIL && at_last));
        shift  = !pwr_dn && (state_q != ST_OFF) && !load;
        clear  = pwr_dn;
        bit_en = (state_q != ST_OFF);
        frame  = (state_q == ST_HEAD);
    end

endmodule

// File: rtl/afr_lane.sv
module afr_lane #(
    parameter int              WORD_W    = 12,
    parameter logic [WORD_W-1:0] TEST_WORD = 12'h0BD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_valid,
    input  logic [WORD_W-1:0] sample_word,
    input  logic              fmt_twos,
    input  logic              test_en,
    input  logic              load,
    input  logic              shift,
    input  logic              clear,
    output logic              ser_bit
);
    logic [WORD_W-1:0] hold_q;
    logic [WORD_W-1:0] next_word;
    logic [WORD_W-1:0] coded;
    logic [WORD_W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            hold_q <= '0;
        else if (sample_valid) hold_q <= sample_word;
    end

    always_comb begin
        next_word = sample_valid ? sample_word : hold_q;
        if (test_en)       coded = TEST_WORD;
        else if (fmt_twos) coded = {~next_word[WORD_W-1], next_word[WORD_W-2:0]};
        else               coded = next_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sh_q <= '0;
        else if (clear) sh_q <= '0;
        else if (load)  sh_q <= coded;
        else if (shift) sh_q <= {1'b0, sh_q[WORD_W-1:1]};
    end

    assign ser_bit = sh_q[0];

endmodule

// File: rtl/adc_lane_framer.sv
module adc_lane_framer #(
    parameter int                NUM_CH    = 4,
    parameter int                WORD_W    = 12,
    parameter logic [WORD_W-1:0] TEST_WORD = 12'h0BD
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sample_valid,
    input  logic [NUM_CH*WORD_W-1:0] sample_data,
    input  logic                     fmt_twos,
    input  logic                     test_en,
    input  logic                     pwr_dn,
    output logic [NUM_CH-1:0]        ser_data,
    output logic                     bit_en,
    output logic                     frame
);
    logic load, shift, clear;

    afr_sequencer #(.WORD_W(WORD_W)) i_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .pwr_dn (pwr_dn),
        .load   (load),
        .shift  (shift),
        .clear  (clear),
        .bit_en (bit_en),
        .frame  (frame)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
        afr_lane #(.WORD_W(WORD_W), .TEST_WORD(TEST_WORD)) i_lane (
            .clk          (clk),
            .rst_n        (rst_n),
            .sample_valid (sample_valid),
            .sample_word  (sample_data[c*WORD_W +: WORD_W]),
            .fmt_twos     (fmt_twos),
            .test_en      (test_en),
            .load         (load),
            .shift        (shift),
            .clear        (clear),
            .ser_bit      (ser_data[c])
        );
    end

endmodule

// File: rtl/afr_checker.sv
module afr_checker #(
    parameter int                NUM_CH    = 4,
    parameter int                WORD_W    = 12,
    parameter logic [WORD_W-1:0] TEST_WORD = 12'h0BD
) (
    input logic              clk,
    input logic              rst_n,
    input logic              test_en,
    input logic              pwr_dn,
    input logic [NUM_CH-1:0] ser_data,
    input logic              bit_en,
    input logic              frame
);
    localparam int PW   = $clog2(WORD_W);
    localparam int HALF = WORD_W / 2;

    // bit-time position of the current cycle, counted from the outside
    logic [PW-1:0] pos;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     pos <= '0;
        else if (!bit_en)               pos <= '0;
        else if (pos == PW'(WORD_W-1))  pos <= '0;
        else                            pos <= pos + 1'b1;
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |-> (ser_data == '0 && !bit_en && !frame));

    p_frame_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en |-> (frame == (pos < PW'(HALF))));

    p_bit_en_resume_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_dn |=> bit_en);

    p_quiet_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> (ser_data == '0 && !bit_en && !frame));

    p_test_first_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && pos == '0 && $past(test_en) && $past(rst_n))
        |-> (ser_data == {NUM_CH{TEST_WORD[0]}}));

endmodule

bind adc_lane_framer afr_checker #(
    .NUM_CH(NUM_CH), .WORD_W(WORD_W), .TEST_WORD(TEST_WORD)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .test_en  (test_en),
    .pwr_dn   (pwr_dn),
    .ser_data (ser_data),
    .bit_en   (bit_en),
    .frame    (frame)
);

// File: tb/test_adc_lane_framer.sv
module test_adc_lane_framer;
    localparam int NUM_CH = 4;
    localparam int WORD_W = 12;
    localparam int DW     = NUM_CH * WORD_W;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          sample_valid;
    logic [DW-1:0] sample_data;
    logic          fmt_twos;
    logic          test_en;
    logic          pwr_dn;
    logic [NUM_CH-1:0] ser_data;
    logic          bit_en;
    logic          frame;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] got;

    always #4 clk = ~clk;

    adc_lane_framer i_adc_lane_framer (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
        .sample_data(sample_data), .fmt_twos(fmt_twos), .test_en(test_en),
        .pwr_dn(pwr_dn), .ser_data(ser_data), .bit_en(bit_en), .frame(frame)
    );

    // {data, fmt_twos, test_en, expected}; channel 0 in the low 12 bits
    localparam logic [2*DW+1:0] VECS [7] = '{
        {48'hABC789456123, 1'b0, 1'b0, 48'hABC789456123},
        {48'h7FFFFF000800, 1'b1, 1'b0, 48'hFFF7FF800000},  // R7 recoding
        {48'h7FFFFF000800, 1'b0, 1'b0, 48'h7FFFFF000800},  // R7 pass-through
        {48'h111222333444, 1'b0, 1'b1, 48'h0BD0BD0BD0BD},  // R8
        {48'h111222333444, 1'b1, 1'b1, 48'h0BD0BD0BD0BD},  // R8 with format 1
        {48'hFFE0015A5A5A, 1'b0, 1'b0, 48'hFFE0015A5A5A},
        {48'hFFE0015A5A5A, 1'b1, 1'b0, 48'h7FE801DA525A}
    };

    task automatic check(input bit ok, input string tag,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // waits for a strobe rise, rebuilds one word per lane, checks R3/R4 shape
    task automatic grab_frame(input bit pf_init, output logic [DW-1:0] word);
        bit pf = pf_init;
        bit shape_ok = 1'b1;
        forever begin
            @(negedge clk);
            if (frame && !pf) break;
            pf = frame;
        end
        for (int b = 0; b < WORD_W; b++) begin
            if (b > 0) @(negedge clk);
            if (bit_en !== 1'b1 || frame !== (b < WORD_W/2)) shape_ok = 1'b0;
            for (int c = 0; c < NUM_CH; c++) word[c*WORD_W + b] = ser_data[c];
        end
        check(shape_ok, "R3 R4 strobe and enable over the frame", {47'd0, shape_ok}, 48'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; sample_valid = 1'b0; sample_data = '0;
        fmt_twos = 1'b0; test_en = 1'b0; pwr_dn = 1'b0;
        repeat (3) @(negedge clk);
        check({ser_data, bit_en, frame} === '0, "R1 reset outputs",
              {42'd0, ser_data, bit_en, frame}, 48'd0);
        @(posedge clk); #1 rst_n = 1'b1;

        // table walk: R2 R7 R8 R10
        for (int v = 0; v < 7; v++) begin
            @(posedge clk); #1;
            sample_valid = 1'b1;
            sample_data  = VECS[v][2*DW+1:DW+2];
            fmt_twos     = VECS[v][DW+1];
            test_en      = VECS[v][DW];
            grab_frame(1'b1, got);
            check(got === VECS[v][DW-1:0], "R2 R10 lane words (R7 R8 coding)",
                  got, VECS[v][DW-1:0]);
        end

        // R5 / R6: boundary capture and hold
        @(posedge clk); #1;
        fmt_twos = 1'b0; test_en = 1'b0;
        sample_data = 48'hC01C02C03C04;
        grab_frame(1'b1, got);
        check(got === 48'hC01C02C03C04, "R5 setup word", got, 48'hC01C02C03C04);
        sample_valid = 1'b0;
        fork
            grab_frame(1'b0, got);
            begin
                @(posedge clk); @(posedge clk); #1;
                sample_valid = 1'b1; sample_data = 48'h0A50B60C70D8;
                @(posedge clk); #1;
                sample_valid = 1'b0; sample_data = 48'hFFFFFFFFFFFF;
            end
        join
        check(got === 48'hC01C02C03C04, "R5 mid-frame valid ignored", got, 48'hC01C02C03C04);
        grab_frame(1'b0, got);
        check(got === 48'h0A50B60C70D8, "R5 word taken at boundary", got, 48'h0A50B60C70D8);
        grab_frame(1'b0, got);
        check(got === 48'h0A50B60C70D8, "R6 held word repeated", got, 48'h0A50B60C70D8);

        // R9: power-down and restart
        pwr_dn = 1'b1;
        @(negedge clk);
        check({ser_data, bit_en, frame} === '0, "R9 R4 outputs quiet after power-down",
              {42'd0, ser_data, bit_en, frame}, 48'd0);
        sample_valid = 1'b1; sample_data = 48'h123456789ABC;
        @(negedge clk);
        sample_valid = 1'b0; sample_data = '0;
        repeat (5) @(negedge clk);
        check({ser_data, bit_en, frame} === '0, "R9 stays quiet while powered down",
              {42'd0, ser_data, bit_en, frame}, 48'd0);
        pwr_dn = 1'b0;
        @(negedge clk);
        check(frame === 1'b1 && bit_en === 1'b1, "R9 restart at bit time 0",
              {46'd0, bit_en, frame}, 48'd3);
        pwr_dn = 1'b1;
        @(negedge clk);
        pwr_dn = 1'b0;
        grab_frame(1'b0, got);
        check(got === 48'h123456789ABC, "R9 first frame after release", got, 48'h123456789ABC);

        finish_run();
    end

endmodule